// File: doc/BRIEF.md
# Memory Protection Region Checker

This block decides, for every memory access, whether one of a set of programmable protection regions covers the address. If one does, it reports the region's number and whether the access is allowed. Each region is programmed with four settings: a base address, a power-of-two size, an enable bit, and an 8-bit mask that removes any of the region's eight equal slices from matching. Each region also carries two 2-bit permission codes, one for privileged accesses and one for unprivileged accesses. When regions overlap, the region with the higher number wins. When no region claims the address, a background setting decides the outcome for privileged accesses. Every other unclaimed access faults.

The checker looks at the access address, the privileged flag and the write flag on every clock. It registers the verdict on the next rising edge. Software programs the regions through a simple write-only port. That port takes a region index, a word selector (base, attributes or global control) and a data word. Every stored setting returns to zero on a synchronous active-low reset.

Top module: `region_guard`

## Requirements
- R1: While `rst_n` is low at a clock edge, `chk_hit`, `chk_fault` and `chk_region` are 0 after that edge. All regions become disabled and the background setting becomes off, so the first access after reset misses and faults.
- R2: The outputs reflect the `acc_*` inputs sampled at the previous rising edge. A region whose size code is c spans 2^(c+1) bytes. It matches an address whose bits above bit c equal the base's bits. The base's low c+1 bits are ignored, so a misaligned base acts as if aligned down.
- R3: A region with enable bit 0 never matches. A region with a size code below 4 (smaller than 32 bytes) never matches.
- R4: A region is split into 8 equal slices, numbered by the three address bits just below its size boundary. When mask bit k is 1, slice k does not match that region. Clearing the bit restores the match.
- R5: When several regions match, `chk_hit` is 1 and `chk_region` names the highest-numbered one. Its permissions alone decide the fault.
- R6: Permission code 00 allows nothing, 01 allows reads only, and 10 or 11 allows reads and writes. The privileged code applies when `acc_priv`=1 and the unprivileged code otherwise. A disallowed access sets `chk_fault`.
- R7: On a miss, `chk_hit` is 0 and `chk_region` is 0. `chk_fault` is 0 only if the access was privileged and the background setting is on.
- R8: The configuration port writes on a clock edge with `cfg_we`=1. `cfg_sel`=0 writes the base of region `cfg_idx`. `cfg_sel`=1 writes its attributes: bit 0 enable, bits 5:1 size code, bits 15:8 slice-disable mask, bits 17:16 privileged code, bits 19:18 unprivileged code. `cfg_sel`=2 writes bit 0 as the background setting.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| cfg_we | input | 1 | Configuration write strobe |
| cfg_idx | input | IDX_W | Region index for the write |
| cfg_sel | input | 2 | Word selector: 0 base, 1 attributes, 2 control |
| cfg_wdata | input | ADDR_W | Configuration write data |
| acc_addr | input | ADDR_W | Access address |
| acc_priv | input | 1 | Access is privileged |
| acc_write | input | 1 | Access is a write |
| chk_hit | output | 1 | A programmed region matched |
| chk_region | output | IDX_W | Winning region number, 0 on a miss |
| chk_fault | output | 1 | The access is not allowed |

## Verification
The bench works through four kinds of corner case.

- **Overlap.** It sends addresses that fall inside a small high-numbered region nested in a larger one. A priority inverter would report the wrong region and apply the wrong permissions.
- **Region edges and size codes.** It probes one byte past a region's end, a misaligned base, and a size code too small to be legal. A design with bad masking would claim a neighbouring address or miss an aligned one.
- **Disabled slices.** It hits a disabled slice, then re-enables it. A design that picked the slice index from the wrong address bits would block the wrong slice.
- **Misses and reset.** It checks the background setting under both privilege levels, and reapplies reset midway through the run. This exposes a grant to unprivileged code on a miss, and configuration that survives reset.

// File: rtl/region_guard_pkg.sv
package region_guard_pkg;

    typedef struct packed {
        logic       en;
        logic [4:0] size_code;
        logic [7:0] slice_off;
        logic [1:0] perm_priv;
        logic [1:0] perm_user;
    } region_attr_t;

    localparam logic [1:0] SEL_BASE = 2'd0;
    localparam logic [1:0] SEL_ATTR = 2'd1;
    localparam logic [1:0] SEL_CTRL = 2'd2;

    localparam logic [4:0] MIN_SIZE_CODE = 5'd4;

    // 00 none, 01 read only, 1x read and write
    function automatic logic perm_allows(input logic [1:0] code, input logic is_write);
        return code[1] | (code[0] & ~is_write);
    endfunction

endpackage

// File: rtl/region_guard_regs.sv
module region_guard_regs
    import region_guard_pkg::*;
#(
    parameter int NUM_REGIONS = 8,
    parameter int ADDR_W      = 32,
    parameter int IDX_W       = 3,
    parameter int NR_EFF      = 8
) (
    input  logic                              clk,
    input  logic                              rst_n,
    input  logic                              cfg_we,
    input  logic [IDX_W-1:0]                  cfg_idx,
    input  logic [1:0]                        cfg_sel,
    input  logic [ADDR_W-1:0]                 cfg_wdata,
    output logic [NR_EFF-1:0][ADDR_W-1:0]     base_q,
    output region_attr_t [NR_EFF-1:0]         attr_q,
    output logic                              bg_en_q
);

    region_attr_t attr_wr;

    always_comb begin
        attr_wr.en        = cfg_wdata[0];
        attr_wr.size_code = cfg_wdata[5:1];
        attr_wr.slice_off = cfg_wdata[15:8];
        attr_wr.perm_priv = cfg_wdata[17:16];
        attr_wr.perm_user = cfg_wdata[19:18];
    end

    for (genvar i = 0; i < NR_EFF; i++) begin : g_reg
        logic sel_me;
        assign sel_me = cfg_we && (NUM_REGIONS > i) && (cfg_idx == IDX_W'(i));

        always_ff @(posedge clk) begin
            if (!rst_n) begin
                base_q[i] <= '0;
                attr_q[i] <= '0;
            end else if (sel_me) begin
                if (cfg_sel == SEL_BASE) base_q[i] <= cfg_wdata;
                if (cfg_sel == SEL_ATTR) attr_q[i] <= attr_wr;
            end
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n)                            bg_en_q <= 1'b0;
        else if (cfg_we && cfg_sel == SEL_CTRL) bg_en_q <= cfg_wdata[0];
    end

endmodule

// File: rtl/region_guard_match.sv
module region_guard_match
    import region_guard_pkg::*;
#(
    parameter int ADDR_W = 32
) (
    input  logic [ADDR_W-1:0] base,
    input  region_attr_t      attr,
    input  logic [ADDR_W-1:0] addr,
    output logic              match
);

    logic [5:0]        size_log2;
    logic [5:0]        slice_lsb;
    logic [ADDR_W-1:0] keep_mask;
    logic              in_range;
    logic [2:0]        slice_idx;

    always_comb begin
        size_log2 = {1'b0, attr.size_code} + 6'd1;
        slice_lsb = size_log2 - 6'd3;
        keep_mask = {ADDR_W{1'b1}} << size_log2;
        in_range  = ((addr ^ base) & keep_mask) == '0;
        slice_idx = 3'b000;
        for (int b = 0; b < ADDR_W; b++) begin
            if (32'(slice_lsb) == b)        slice_idx[0] = addr[b];
            if (32'(slice_lsb) + 1 == b)    slice_idx[1] = addr[b];
            if (32'(slice_lsb) + 2 == b)    slice_idx[2] = addr[b];
        end
        match = attr.en && (attr.size_code >= MIN_SIZE_CODE) && in_range
                && !attr.slice_off[slice_idx];
    end

endmodule

// File: rtl/region_guard_resolve.sv
module region_guard_resolve
    import region_guard_pkg::*;
#(
    parameter int IDX_W  = 3,
    parameter int NR_EFF = 8
) (
    input  logic [NR_EFF-1:0]      match,
    input  logic [NR_EFF-1:0][1:0] perm_priv,
    input  logic [NR_EFF-1:0][1:0] perm_user,
    input  logic                   priv,
    input  logic                   is_write,
    input  logic                   bg_en,
    output logic                   hit,
    output logic [IDX_W-1:0]       region,
    output logic                   fault
);

    logic [1:0] code;

    always_comb begin
        hit    = 1'b0;
        region = '0;
        code   = 2'b00;
        for (int i = 0; i < NR_EFF; i++) begin
            if (match[i]) begin
                hit    = 1'b1;
                region = IDX_W'(i);
                code   = priv ? perm_priv[i] : perm_user[i];
            end
        end
        if (hit) fault = !perm_allows(code, is_write);
        else     fault = !(priv && bg_en);
    end

endmodule

// File: rtl/region_guard.sv
module region_guard
    import region_guard_pkg::*;
#(
    parameter int NUM_REGIONS = 8,
    parameter int ADDR_W      = 32,
    parameter int IDX_W       = (NUM_REGIONS > 1) ? $clog2(NUM_REGIONS) : 1
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              cfg_we,
    input  logic [IDX_W-1:0]  cfg_idx,
    input  logic [1:0]        cfg_sel,
    input  logic [ADDR_W-1:0] cfg_wdata,
    input  logic [ADDR_W-1:0] acc_addr,
    input  logic              acc_priv,
    input  logic              acc_write,
    output logic              chk_hit,
    output logic [IDX_W-1:0]  chk_region,
    output logic              chk_fault
);

    localparam int NR_EFF = (NUM_REGIONS > 0) ? NUM_REGIONS : 1;

    logic [NR_EFF-1:0][ADDR_W-1:0] base_q;
    region_attr_t [NR_EFF-1:0]     attr_q;
    logic                          bg_en_q;
    logic [NR_EFF-1:0]             match;
    logic [NR_EFF-1:0][1:0]        perm_priv;
    logic [NR_EFF-1:0][1:0]        perm_user;
    logic                          hit_d;
    logic [IDX_W-1:0]              region_d;
    logic                          fault_d;

    region_guard_regs #(
        .NUM_REGIONS(NUM_REGIONS), .ADDR_W(ADDR_W), .IDX_W(IDX_W), .NR_EFF(NR_EFF)
    ) u_regs (
        .clk(clk), .rst_n(rst_n), .cfg_we(cfg_we), .cfg_idx(cfg_idx),
        .cfg_sel(cfg_sel), .cfg_wdata(cfg_wdata),
        .base_q(base_q), .attr_q(attr_q), .bg_en_q(bg_en_q)
    );

    if (NUM_REGIONS > 0) begin : g_cmp
        for (genvar i = 0; i < NR_EFF; i++) begin : g_rgn
            region_guard_match #(.ADDR_W(ADDR_W)) u_match (
                .base(base_q[i]), .attr(attr_q[i]), .addr(acc_addr), .match(match[i])
            );
        end
    end else begin : g_none
        assign match = '0;
    end

    for (genvar i = 0; i < NR_EFF; i++) begin : g_perm
        assign perm_priv[i] = attr_q[i].perm_priv;
        assign perm_user[i] = attr_q[i].perm_user;
    end

    region_guard_resolve #(.IDX_W(IDX_W), .NR_EFF(NR_EFF)) u_resolve (
        .match(match), .perm_priv(perm_priv), .perm_user(perm_user),
        .priv(acc_priv), .is_write(acc_write), .bg_en(bg_en_q),
        .hit(hit_d), .region(region_d), .fault(fault_d)
    );

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            chk_hit    <= 1'b0;
            chk_region <= '0;
            chk_fault  <= 1'b0;
        end else begin
            chk_hit    <= hit_d;
            chk_region <= region_d;
            chk_fault  <= fault_d;
        end
    end

endmodule

// File: rtl/region_guard_sva.sv
module region_guard_sva #(
    parameter int NUM_REGIONS = 8,
    parameter int IDX_W       = 3
) (
    input logic             clk,
    input logic             rst_n,
    input logic             acc_priv,
    input logic             bg_en,
    input logic             chk_hit,
    input logic [IDX_W-1:0] chk_region,
    input logic             chk_fault
);

    logic armed;
    always_ff @(posedge clk) begin
        if (!rst_n) armed <= 1'b0;
        else        armed <= 1'b1;
    end

    // R1
    reset_clear_chk: assert property (@(posedge clk)
        !rst_n |=> (!chk_hit && !chk_fault && chk_region == '0));

    // R7
    miss_region_zero_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !chk_hit |-> chk_region == '0);

    // R7
    user_miss_fault_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (armed && !chk_hit && !$past(acc_priv)) |-> chk_fault);

    // R7
    priv_bg_grant_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (armed && !chk_hit && $past(acc_priv) && $past(bg_en)) |-> !chk_fault);

    if (NUM_REGIONS > 0) begin : g_rng
        // R5
        region_range_chk: assert property (@(posedge clk) disable iff (!rst_n)
            chk_hit |-> (32'(chk_region) < NUM_REGIONS));
    end else begin : g_nohit
        // R3
        no_region_hit_chk: assert property (@(posedge clk) disable iff (!rst_n)
            !chk_hit);
    end

endmodule

bind region_guard region_guard_sva #(.NUM_REGIONS(NUM_REGIONS), .IDX_W(IDX_W)) u_sva (
    .clk(clk), .rst_n(rst_n), .acc_priv(acc_priv), .bg_en(bg_en_q),
    .chk_hit(chk_hit), .chk_region(chk_region), .chk_fault(chk_fault)
);

// File: tb/region_guard_bench.sv
module region_guard_bench;

    typedef struct packed {
        logic [31:0] addr;
        logic        priv;
        logic        wr;
        logic        hit;
        logic [2:0]  region;
        logic        fault;
        logic [3:0]  req;
    } vec_t;

    localparam int NV = 15;
    localparam vec_t VECS [NV] = '{
        '{32'h0000_0100, 1'b0, 1'b0, 1'b1, 3'd0, 1'b0, 4'd2}, // R2 user read of RO
        '{32'h0000_0100, 1'b0, 1'b1, 1'b1, 3'd0, 1'b1, 4'd6}, // R6 user write of RO
        '{32'h0000_0100, 1'b1, 1'b1, 1'b1, 3'd0, 1'b0, 4'd6}, // R6 priv write RW
        '{32'h0000_1004, 1'b1, 1'b1, 1'b1, 3'd1, 1'b0, 4'd5}, // R5 overlap r1 over r0
        '{32'h0000_1004, 1'b0, 1'b0, 1'b1, 3'd1, 1'b1, 4'd5}, // R5 r1 user none
        '{32'h0000_1810, 1'b1, 1'b0, 1'b1, 3'd7, 1'b1, 4'd5}, // R5 r7 wins, none
        '{32'h0000_1820, 1'b1, 1'b0, 1'b1, 3'd1, 1'b0, 4'd2}, // R2 just past r7
        '{32'h2000_0010, 1'b0, 1'b0, 1'b1, 3'd2, 1'b0, 4'd4}, // R4 enabled slice
        '{32'h2000_0044, 1'b0, 1'b0, 1'b0, 3'd0, 1'b1, 4'd4}, // R4 disabled slice 2
        '{32'h2000_0060, 1'b1, 1'b1, 1'b1, 3'd2, 1'b1, 4'd6}, // R6 priv write RO
        '{32'h3000_0004, 1'b0, 1'b1, 1'b1, 3'd3, 1'b0, 4'd2}, // R2 misaligned base
        '{32'h3000_0024, 1'b1, 1'b0, 1'b0, 3'd0, 1'b1, 4'd2}, // R2 past 32-byte end
        '{32'h4000_0000, 1'b1, 1'b0, 1'b0, 3'd0, 1'b1, 4'd3}, // R3 disabled region
        '{32'h5000_0000, 1'b1, 1'b0, 1'b0, 3'd0, 1'b1, 4'd3}, // R3 size code too small
        '{32'h0001_0000, 1'b1, 1'b0, 1'b0, 3'd0, 1'b1, 4'd7}  // R7 miss, bg off
    };

    logic        clk = 1'b0;
    logic        rst_n;
    logic        cfg_we;
    logic [2:0]  cfg_idx;
    logic [1:0]  cfg_sel;
    logic [31:0] cfg_wdata;
    logic [31:0] acc_addr;
    logic        acc_priv;
    logic        acc_write;
    logic        chk_hit;
    logic [2:0]  chk_region;
    logic        chk_fault;

    int errors = 0;
    int checks = 0;

    always #4 clk = ~clk;

    region_guard u_region_guard (
        .clk(clk), .rst_n(rst_n), .cfg_we(cfg_we), .cfg_idx(cfg_idx),
        .cfg_sel(cfg_sel), .cfg_wdata(cfg_wdata), .acc_addr(acc_addr),
        .acc_priv(acc_priv), .acc_write(acc_write), .chk_hit(chk_hit),
        .chk_region(chk_region), .chk_fault(chk_fault)
    );

    function automatic logic [31:0] attr_word(input logic en, input logic [4:0] code,
                                              input logic [7:0] off, input logic [1:0] pp,
                                              input logic [1:0] pu);
        return {12'b0, pu, pp, off, 2'b00, code, en};
    endfunction

    task automatic cfg_write(input logic [2:0] idx, input logic [1:0] sel, input logic [31:0] d);
        @(negedge clk);
        cfg_we = 1'b1; cfg_idx = idx; cfg_sel = sel; cfg_wdata = d;
        @(negedge clk);
        cfg_we = 1'b0;
    endtask

    task automatic check(input string req, input logic [4:0] act, input logic [4:0] exp_v,
                         input logic [31:0] addr);
        checks++;
        if (act !== exp_v) begin
            errors++;
            $display("FAIL %s addr=%h actual hit/region/fault=%b expected=%b", req, addr, act, exp_v);
        end
    endtask

    task automatic access(input string req, input logic [31:0] a, input logic p, input logic w,
                          input logic eh, input logic [2:0] er, input logic ef);
        @(negedge clk);
        acc_addr = a; acc_priv = p; acc_write = w;
        @(negedge clk);
        check(req, {chk_hit, chk_region, chk_fault}, {eh, er, ef}, a);
    endtask

    initial begin
        repeat (100000) @(posedge clk);
        errors++;
        $display("FAIL watchdog expired");
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end

    initial begin
        rst_n = 1'b0; cfg_we = 1'b0; cfg_idx = '0; cfg_sel = '0; cfg_wdata = '0;
        acc_addr = '0; acc_priv = 1'b0; acc_write = 1'b0;
        repeat (3) @(negedge clk);
        check("R1", {chk_hit, chk_region, chk_fault}, 5'b0, 32'h0);
        rst_n = 1'b1;

        // R8 programming through the configuration port
        cfg_write(3'd0, 2'd0, 32'h0000_0000);
        cfg_write(3'd0, 2'd1, attr_word(1'b1, 5'd15, 8'h00, 2'b10, 2'b01));
        cfg_write(3'd1, 2'd0, 32'h0000_1000);
        cfg_write(3'd1, 2'd1, attr_word(1'b1, 5'd11, 8'h00, 2'b10, 2'b00));
        cfg_write(3'd2, 2'd0, 32'h2000_0000);
        cfg_write(3'd2, 2'd1, attr_word(1'b1, 5'd7, 8'h04, 2'b01, 2'b01));
        cfg_write(3'd3, 2'd0, 32'h3000_0010);
        cfg_write(3'd3, 2'd1, attr_word(1'b1, 5'd4, 8'h00, 2'b10, 2'b10));
        cfg_write(3'd4, 2'd0, 32'h4000_0000);
        cfg_write(3'd4, 2'd1, attr_word(1'b0, 5'd9, 8'h00, 2'b10, 2'b10));
        cfg_write(3'd5, 2'd0, 32'h5000_0000);
        cfg_write(3'd5, 2'd1, attr_word(1'b1, 5'd3, 8'h00, 2'b10, 2'b10));
        cfg_write(3'd7, 2'd0, 32'h0000_1800);
        cfg_write(3'd7, 2'd1, attr_word(1'b1, 5'd4, 8'h00, 2'b00, 2'b00));

        for (int i = 0; i < NV; i++) begin
            access($sformatf("R%0d", VECS[i].req), VECS[i].addr, VECS[i].priv, VECS[i].wr,
                   VECS[i].hit, VECS[i].region, VECS[i].fault);
        end

        // R7 background on: privileged miss granted, unprivileged miss faults
        cfg_write(3'd0, 2'd2, 32'h0000_0001);
        access("R7", 32'h0001_0000, 1'b1, 1'b0, 1'b0, 3'd0, 1'b0);
        access("R7", 32'h0001_0000, 1'b0, 1'b0, 1'b0, 3'd0, 1'b1);

        // R4 clearing the slice mask restores the match
        cfg_write(3'd2, 2'd1, attr_word(1'b1, 5'd7, 8'h00, 2'b01, 2'b01));
        access("R4", 32'h2000_0044, 1'b0, 1'b0, 1'b1, 3'd2, 1'b0);

        // R6 code 11 acts as read-write
        cfg_write(3'd3, 2'd1, attr_word(1'b1, 5'd4, 8'h00, 2'b11, 2'b11));
        access("R6", 32'h3000_0008, 1'b0, 1'b1, 1'b1, 3'd3, 1'b0);

        // R1 reset mid-run clears regions and background setting
        @(negedge clk);
        rst_n = 1'b0;
        @(negedge clk);
        check("R1", {chk_hit, chk_region, chk_fault}, 5'b0, 32'h0);
        rst_n = 1'b1;
        access("R1", 32'h0000_0100, 1'b1, 1'b0, 1'b0, 3'd0, 1'b1);

        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end

endmodule